// File: doc/BRIEF.md
# Register-Mask Save/Restore Sequencer

This block saves a chosen group of general registers to a stack in memory, or restores them from it. A command names the direction and carries a 16-bit selection mask. Mask bit n selects register n, for registers 0 to 14. Bit 15 has no meaning and is dropped.

For each selected register the sequencer reads the register file and writes one 32-bit word to memory, or reads one word from memory and writes it to the register file. It never spends a cycle on a register that is not selected. The stack grows downward:

- A save lowers the stack pointer by four before each write. It visits registers from the highest number to the lowest, so a higher-numbered register ends up at a higher address.
- A restore reads at the stack pointer and then raises it by four. It visits registers from the lowest number to the highest, which undoes a save made with the same mask.

When every selected register has been moved, a one-cycle done strobe is raised together with the final stack pointer. The condition-code flags pass through the block untouched. The register file and the memory are outside the block.

Top module: `regstack_seq`

## Requirements
- R1: Register n (0..14) moves only when mask bit n is set. Mask bit 15 has no effect. A restore writes no register whose bit is clear.
- R2: A save visits the selected registers in descending order. Each write goes to the current stack pointer minus 4, and the pointer takes that value on acknowledge. After the save, the word at final_sp+4*j holds the j-th selected register, counting j upward from the lowest number.
- R3: A restore visits the selected registers in ascending order. Each read comes from the current stack pointer, and the pointer grows by 4 on acknowledge.
- R4: Each selected register costs exactly one memory request. The request, address and direction stay steady until the acknowledge arrives.
- R5: When mask bits 14..0 are all zero, done rises in the cycle after the command is taken. No memory request is made and the stack pointer returns unchanged.
- R6: In the cycle done is high, sp_out equals sp_in minus 4 times the selected count for a save, or plus that amount for a restore.
- R7: cc_out always equals cc_in, including while a pass runs.
- R8: cmd_ready is high only when the block is idle. A command offered while a pass runs is ignored.
- R9: rf_we is high only during a restore, and only in the cycle the memory acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_pop | input | 1 | 1 = restore from stack, 0 = save to stack |
| cmd_mask | input | 16 | Register selection mask, bit n = register n |
| cmd_ready | output | 1 | Idle, a command can be taken |
| sp_in | input | 32 | Stack pointer at command time |
| sp_out | output | 32 | Working stack pointer, final value with done |
| done | output | 1 | One-cycle end-of-pass strobe |
| cc_in | input | 4 | Condition flags N,Z,V,C in |
| cc_out | output | 4 | Condition flags out, unchanged |
| rf_addr | output | 4 | Register file index of the current register |
| rf_rdata | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_wdata | output | 32 | Register file write data |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The properties rely on the memory raising mem_ack only while mem_req is high, and for a single cycle at a time. The stimulus meets this because its memory model raises mem_ack for exactly one cycle per request, after a chosen wait, and drops it at the next falling edge. The properties also rely on the register file returning data combinationally for rf_addr. The bench model does this, holds a value for every index 0..14, and the stimulus keeps stack addresses inside the modelled memory window.

// File: rtl/regstack_pkg.sv
package regstack_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NREG   = 15;
  localparam int unsigned MASK_W = 16;
  localparam int unsigned IDX_W  = $clog2(NREG);
  localparam int unsigned WORD_B = DATA_W / 8;

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} seq_state_e;

  // byte address touched by the current transfer
  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] sp,
                                                  input logic pop);
    return pop ? sp : sp - ADDR_W'(WORD_B);
  endfunction

  // stack pointer after the current transfer completes
  function automatic logic [ADDR_W-1:0] sp_after(input logic [ADDR_W-1:0] sp,
                                                 input logic pop);
    return pop ? sp + ADDR_W'(WORD_B) : sp - ADDR_W'(WORD_B);
  endfunction
endpackage

// File: rtl/regstack_pick.sv
module regstack_pick #(
  parameter int unsigned N  = 15,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  input  logic          low_first,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [IW-1:0] lo_idx, hi_idx;

  // lowest set bit: scan downward, last hit wins
  always_comb begin
    lo_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (pend[i]) lo_idx = IW'(i);
  end

  // highest set bit: scan upward, last hit wins
  always_comb begin
    hi_idx = '0;
    for (int i = 0; i < N; i++)
      if (pend[i]) hi_idx = IW'(i);
  end

  assign any = |pend;
  assign idx = low_first ? lo_idx : hi_idx;
endmodule

// File: rtl/regstack_addr.sv
module regstack_addr
  import regstack_pkg::*;
(
  input  logic [ADDR_W-1:0] sp,
  input  logic              pop,
  output logic [ADDR_W-1:0] access_addr,
  output logic [ADDR_W-1:0] sp_next
);
  assign access_addr = slot_addr(sp, pop);
  assign sp_next     = sp_after(sp, pop);
endmodule

// File: rtl/regstack_seq.sv
module regstack_seq
  import regstack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_pop,
  input  logic [MASK_W-1:0] cmd_mask,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] sp_in,
  output logic [ADDR_W-1:0] sp_out,
  output logic              done,
  input  logic [3:0]        cc_in,
  output logic [3:0]        cc_out,
  output logic [IDX_W-1:0]  rf_addr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  seq_state_e        state_q;
  logic [NREG-1:0]   pend_q;
  logic              pop_q;
  logic [ADDR_W-1:0] sp_q;

  logic [IDX_W-1:0]  cur_idx;
  logic              cur_any;
  logic [ADDR_W-1:0] acc_addr, sp_adv;
  logic              xfer_live, xfer_fin, take_cmd;
  logic [NREG-1:0]   clr_vec;

  regstack_pick #(.N(NREG), .IW(IDX_W)) u_pick (
    .pend(pend_q), .low_first(pop_q), .idx(cur_idx), .any(cur_any)
  );

  regstack_addr u_addr (
    .sp(sp_q), .pop(pop_q), .access_addr(acc_addr), .sp_next(sp_adv)
  );

  assign take_cmd  = (state_q == ST_IDLE) && cmd_valid;
  assign xfer_live = (state_q == ST_RUN) && cur_any;
  assign xfer_fin  = xfer_live && mem_ack;
  assign clr_vec   = NREG'(1) << cur_idx;

  assign cmd_ready = (state_q == ST_IDLE);
  assign done      = (state_q == ST_RUN) && !cur_any;
  assign sp_out    = sp_q;
  assign cc_out    = cc_in;

  assign rf_addr   = cur_idx;
  assign rf_we     = xfer_fin && pop_q;
  assign rf_wdata  = mem_rdata;
  assign mem_req   = xfer_live;
  assign mem_we    = xfer_live && !pop_q;
  assign mem_addr  = acc_addr;
  assign mem_wdata = rf_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      pop_q   <= 1'b0;
      sp_q    <= '0;
    end else begin
      if (take_cmd) begin
        pend_q  <= cmd_mask[NREG-1:0];
        pop_q   <= cmd_pop;
        sp_q    <= sp_in;
        state_q <= ST_RUN;
      end
      if (xfer_fin) begin
        pend_q <= pend_q & ~clr_vec;
        sp_q   <= sp_adv;
      end
      if (done) state_q <= ST_IDLE;
    end
  end
endmodule

// File: rtl/regstack_seq_chk.sv
module regstack_seq_chk
  import regstack_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [MASK_W-1:0] cmd_mask,
  input logic              done,
  input logic [ADDR_W-1:0] sp_out,
  input logic              rf_we,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R4
  AST_SAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_we) |=> (!mem_req || mem_addr == $past(mem_addr) - ADDR_W'(WORD_B))); // R2
  AST_RESTORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_we) |=> (!mem_req || mem_addr == $past(mem_addr) + ADDR_W'(WORD_B))); // R3
  AST_SAVE_SP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_we) |=> (sp_out == $past(mem_addr))); // R6
  AST_RESTORE_SP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_we) |=> (sp_out == $past(mem_addr) + ADDR_W'(WORD_B))); // R6
  AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_mask[NREG-1:0] == '0) |=> (done && !mem_req)); // R5
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || done) |-> !cmd_ready); // R8
  AST_RFWE_ONLY_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (mem_req && mem_ack && !mem_we)); // R9
endmodule

bind regstack_seq regstack_seq_chk u_chk (.*);

// File: tb/regstack_seq_test.sv
`timescale 1ns/1ps
module regstack_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_pop = 1'b0;
  logic [15:0] cmd_mask = '0;
  logic        cmd_ready, done, rf_we, mem_req, mem_we;
  logic [31:0] sp_in = '0, sp_out, rf_rdata, rf_wdata, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic [3:0]  cc_in = '0, cc_out, rf_addr;

  always #2 clk = ~clk;

  regstack_seq uut (.*);

  logic [31:0] rf [15];
  logic [31:0] mem [64];
  int lat = 0, wcnt = 0, n_acks = 0, n_rfw = 0;
  logic [3:0] ack_log [64];
  int vecs = 0, errs = 0, cycles = 0;

  assign rf_rdata = rf[rf_addr];
  always @(posedge clk) if (rf_we) begin rf[rf_addr] <= rf_wdata; n_rfw <= n_rfw + 1; end

  // memory model: one-cycle ack after lat waiting cycles
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      if (wcnt >= lat) begin
        mem_ack <= 1'b1; wcnt <= 0;
        ack_log[n_acks % 64] <= rf_addr;
        n_acks <= n_acks + 1;
        if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        else mem_rdata <= mem[mem_addr[7:2]];
      end else wcnt <= wcnt + 1;
    end else mem_ack <= 1'b0;
  end

  function automatic logic [31:0] reg_val(input int i);
    return 32'hC0DE_0000 + i * 32'h0101_0011;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_cmd(input bit pop, input logic [15:0] mask, input logic [31:0] sp,
                         output logic [31:0] sp_end, output int cyc, output int base);
    @(negedge clk);
    base = n_acks;
    cmd_pop = pop; cmd_mask = mask; sp_in = sp; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cyc = 1;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    sp_end = sp_out;
  endtask

  task automatic t_reset;
    chk("R8", "ready after reset", {31'b0, cmd_ready}, 32'd1);
    chk("R5", "done after reset", {31'b0, done}, 32'd0);
    chk("R4", "req after reset", {31'b0, mem_req}, 32'd0);
  endtask

  task automatic t_empty(input bit pop, input logic [15:0] mask);
    logic [31:0] spe; int cyc, base;
    run_cmd(pop, mask, 32'h0000_0080, spe, cyc, base);
    chk("R5", "empty mask cycles", cyc, 1);
    chk("R5", "empty mask traffic", n_acks - base, 0);
    chk("R5", "empty mask sp", spe, 32'h0000_0080);
  endtask

  task automatic t_roundtrip(input logic [15:0] mask, input int l);
    logic [31:0] spe, sp0; int cyc, base, k, j, rfw0, prev;
    sp0 = 32'h0000_00F0; lat = l; k = 0;
    for (int i = 0; i < 15; i++) begin rf[i] = reg_val(i); if (mask[i]) k++; end
    run_cmd(1'b0, mask, sp0, spe, cyc, base);
    chk("R6", "save final sp", spe, sp0 - 32'(4 * k));
    chk("R4", "save request count", n_acks - base, k);
    prev = 99;
    for (int a = 0; a < k; a++) begin
      if (!(int'(ack_log[(base + a) % 64]) < prev)) chk("R2", "save order", ack_log[(base + a) % 64], prev);
      prev = int'(ack_log[(base + a) % 64]);
    end
    vecs++;
    j = 0;
    for (int i = 0; i < 15; i++) if (mask[i]) begin
      chk("R2", "saved word placement", mem[(spe[7:2] + j) % 64], reg_val(i)); j++;
    end
    for (int i = 0; i < 15; i++) rf[i] = 32'h0;
    rfw0 = n_rfw;
    run_cmd(1'b1, mask, spe, spe, cyc, base);
    chk("R6", "restore final sp", spe, sp0);
    chk("R9", "restore rf write count", n_rfw - rfw0, k);
    prev = -1;
    for (int a = 0; a < k; a++) begin
      if (!(int'(ack_log[(base + a) % 64]) > prev)) chk("R3", "restore order", ack_log[(base + a) % 64], prev);
      prev = int'(ack_log[(base + a) % 64]);
    end
    vecs++;
    for (int i = 0; i < 15; i++)
      chk("R1", "restored register", rf[i], mask[i] ? reg_val(i) : 32'h0);
    lat = 0;
  endtask

  task automatic t_busy;
    logic [31:0] spe; int cyc, base;
    for (int i = 0; i < 15; i++) rf[i] = reg_val(i);
    lat = 3;
    @(negedge clk);
    base = n_acks;
    cmd_pop = 1'b0; cmd_mask = 16'h0003; sp_in = 32'h0000_00C0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_pop = 1'b1; cmd_mask = 16'h7FFF;
    @(negedge clk);
    chk("R8", "ready while busy", {31'b0, cmd_ready}, 32'd0);
    cmd_valid = 1'b0; cyc = 2;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    spe = sp_out;
    chk("R8", "busy command ignored sp", spe, 32'h0000_00B8);
    repeat (4) @(negedge clk);
    chk("R8", "no extra traffic", n_acks - base, 2);
    lat = 0;
  endtask

  task automatic t_cc;
    logic [31:0] spe; int cyc, base;
    for (int v = 0; v < 16; v += 5) begin
      cc_in = 4'(v); #1;
      chk("R7", "flags idle", {28'b0, cc_out}, 32'(v));
    end
    cc_in = 4'hA;
    fork
      run_cmd(1'b0, 16'h0410, 32'h0000_0100, spe, cyc, base);
      begin repeat (2) @(negedge clk); chk("R7", "flags busy", {28'b0, cc_out}, 32'hA); end
    join
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 100000) begin
        errs++; vecs++;
        $display("FAIL watchdog: actual %0d expected below 100000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 15; i++) rf[i] = 32'h0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty(1'b0, 16'h8000);
    t_empty(1'b1, 16'h0000);
    t_roundtrip(16'h8005, 0);
    t_roundtrip(16'h7FFF, 2);
    t_roundtrip(16'h4000, 1);
    t_roundtrip(16'hA241, 0);
    t_busy();
    t_cc();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule